// File: doc/BRIEF.md
# Gated Carrier Phase Accumulator

This block is the phase engine of a carrier oscillator in one downconverter channel. It keeps a programmable frequency word and a phase accumulator that wraps modulo 2^ACC_W. On every clock where the channel enable input is high, the accumulator grows by the active frequency word. A coarse offset, counted in eighths of a cycle, is added into the top bits of the phase. The result is registered and sent to a downstream sine/cosine stage.

Software reaches the block through a small register write port. Address 0 takes the frequency word. Address 1 takes the control word. A new frequency word always lands in a shadow register. It is copied to the active register either at once or on the next sync pulse, depending on a control bit. Two further control bits clear the accumulator. One clears it continuously, which gives a fixed phase for tests or for mixer bypass. The other clears it only in the cycle when the active frequency register is reloaded.

Top module: `carrier_phase_acc`

## Requirements
- R1: After a synchronous active-high reset, the accumulator, the active and shadow frequency words, the control word and `phase_out` are all zero.
- R2: When `enable` is high and no clear applies, the accumulator gains the active frequency word at each clock and wraps modulo 2^ACC_W.
- R3: When `enable` is low and no clear applies, the accumulator holds its value, so `phase_out` stays constant.
- R4: `phase_out` is registered. It equals the accumulator value from the previous clock plus the offset field N (control bits 5:3) placed in the top 3 bits, which means N·π/4 of phase.
- R5: While the continuous-clear bit (control bit 1) is set, the accumulator is forced to zero whatever `enable` does. `phase_out` then settles at N·2^(ACC_W-3).
- R6: When the clear-on-load bit (control bit 2) is set, the accumulator is zeroed for exactly the one clock in which the active frequency register is reloaded. An enabled advance in that clock is skipped.
- R7: When the defer bit (control bit 0) is set, a frequency write updates only the shadow word. Each clock with `sync_in` high copies the shadow word into the active register, and that copy counts as a reload.
- R8: When the defer bit is clear, a write to address 0 loads the active register at the same clock edge. The accumulator first uses the new word at the following enabled clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = frequency word, 1 = control word |
| wr_data | input | ACC_W | Write data |
| enable | input | 1 | Clock-enable that gates accumulator advance |
| sync_in | input | 1 | Sync pulse that transfers a deferred frequency word |
| phase_out | output | ACC_W | Registered phase word with the offset applied |

## Verification
The bench uses the default parameters, a 32-bit accumulator and a 3-bit offset. With these values, a frequency word of 0x60000000 wraps the accumulator within three enabled clocks, and every one of the eight offset steps lands in a visible top-bit pattern of the phase word. The bench also drives clocks where a sync pulse and a frequency write coincide, and clocks where a clear and an enable coincide. Both cases are then compared against the reference model on each clock.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int OFS_W  = 3;
  localparam int CTRL_W = OFS_W + 3;

  localparam logic ADDR_FREQ = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // control word layout: [5:3] offset, [2] clear on reload, [1] hold cleared, [0] wait for sync
  typedef struct packed {
    logic [OFS_W-1:0] ofs;
    logic             clr_load;
    logic             clr_cont;
    logic             defer;
  } nco_ctrl_t;
endpackage

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             sync_in,
  output logic [ACC_W-1:0] freq_act,
  output nco_ctrl_t        ctrl,
  output logic             load_evt
);
  logic [ACC_W-1:0] freq_sh;
  logic             load_now;
  logic             load_sync;

  assign load_now  = wr_en && (wr_addr == ADDR_FREQ) && !ctrl.defer;
  assign load_sync = ctrl.defer && sync_in;
  assign load_evt  = load_now || load_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_sh  <= '0;
      freq_act <= '0;
      ctrl     <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_FREQ) freq_sh <= wr_data;
      if (wr_en && wr_addr == ADDR_CTRL) ctrl <= nco_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (load_now)       freq_act <= wr_data;
      else if (load_sync) freq_act <= freq_sh;
    end
  end

  // R7
  defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.defer && !sync_in) |=> $stable(freq_act));

  // R8
  immediate_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_FREQ && !ctrl.defer) |=> (freq_act == $past(wr_data)));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [ACC_W-1:0] freq_act,
  input  logic             clr_cont,
  input  logic             clr_load,
  input  logic             load_evt,
  output logic [ACC_W-1:0] acc
);
  logic clr;

  assign clr = clr_cont || (clr_load && load_evt);

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (clr)    acc <= '0;
    else if (enable) acc <= acc + freq_act;
  end

  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clr_cont && !load_evt) |=> $stable(acc));

  // R5
  cont_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cont |=> (acc == '0));

  // R6
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_load && load_evt) |=> (acc == '0));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic [OFS_W-1:0] ofs,
  output logic [ACC_W-1:0] phase_out
);
  localparam int PAD_W = ACC_W - OFS_W;

  logic [ACC_W-1:0] ofs_ext;

  assign ofs_ext = {ofs, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) phase_out <= '0;
    else     phase_out <= acc + ofs_ext;
  end
endmodule

// File: rtl/carrier_phase_acc.sv
module carrier_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             enable,
  input  logic             sync_in,
  output logic [ACC_W-1:0] phase_out
);
  logic [ACC_W-1:0] freq_act;
  logic [ACC_W-1:0] acc;
  nco_ctrl_t        ctrl;
  logic             load_evt;

  nco_ctrl_regs #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .freq_act(freq_act), .ctrl(ctrl), .load_evt(load_evt)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .enable(enable), .freq_act(freq_act),
    .clr_cont(ctrl.clr_cont), .clr_load(ctrl.clr_load), .load_evt(load_evt), .acc(acc)
  );

  nco_phase_out #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_out (
    .clk(clk), .rst(rst), .acc(acc), .ofs(ctrl.ofs), .phase_out(phase_out)
  );

  // R4
  zero_phase_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == '0) |=> (phase_out[ACC_W-1 -: OFS_W] == $past(ctrl.ofs)));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !ctrl.clr_cont && !load_evt) |=> (acc == $past(acc) + $past(freq_act)));
endmodule

// File: tb/tb_carrier_phase_acc.sv
module tb_carrier_phase_acc;
  localparam int ACC_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             wr_addr = 1'b0;
  logic [ACC_W-1:0] wr_data = '0;
  logic             enable = 1'b0;
  logic             sync_in = 1'b0;
  logic [ACC_W-1:0] phase_out;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  bit [31:0] m_acc, m_act, m_sh, m_phase;
  bit [2:0]  m_ofs;
  bit        m_defer, m_clrc, m_clrl;

  carrier_phase_acc #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable(enable), .sync_in(sync_in), .phase_out(phase_out)
  );

  always #10 clk = ~clk;

  // behavioural reference, advanced on each rising edge from the inputs held since the falling edge
  always @(posedge clk) begin
    bit        ld;
    bit [31:0] nact;
    if (rst) begin
      m_acc = 0; m_act = 0; m_sh = 0; m_phase = 0;
      m_ofs = 0; m_defer = 0; m_clrc = 0; m_clrl = 0;
    end else begin
      ld = 0;
      nact = m_act;
      if (wr_en && !wr_addr && !m_defer) begin ld = 1; nact = wr_data; end
      else if (m_defer && sync_in)       begin ld = 1; nact = m_sh; end
      m_phase = m_acc + (32'(m_ofs) << 29);
      if (m_clrc || (ld && m_clrl)) m_acc = 0;
      else if (enable)              m_acc = m_acc + m_act;
      m_act = nact;
      if (wr_en && !wr_addr) m_sh = wr_data;
      if (wr_en && wr_addr) {m_ofs, m_clrl, m_clrc, m_defer} = wr_data[5:0];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: phase_out=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(cur_req, phase_out, m_phase);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  logic [31:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    check("R1", phase_out, 32'h0);
    tick();
    check("R1", phase_out, 32'h0);

    // immediate load and free running advance
    cur_req = "R8";
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h1000_0000);
    enable = 1'b1;
    ticks(3);
    check("R8", phase_out, 32'h2000_0000);

    // wrap around
    cur_req = "R2";
    wr(1'b0, 32'h6000_0000);
    ticks(6);

    // gating: hold, then alternate
    cur_req = "R3";
    enable = 1'b0;
    tick();
    held = phase_out;
    ticks(4);
    check("R3", phase_out, held);
    for (int i = 0; i < 8; i++) begin enable = i[0]; tick(); end
    enable = 1'b1;

    // coarse offset sweep
    cur_req = "R4";
    for (int n = 0; n < 8; n++) begin
      wr(1'b1, 32'(n) << 3);
      ticks(2);
    end

    // deferred update, including a write together with a sync pulse
    cur_req = "R7";
    wr(1'b1, 32'h0000_0019);
    wr(1'b0, 32'h0100_0000);
    ticks(3);
    sync_in = 1'b1; tick(); sync_in = 1'b0;
    ticks(3);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0300_0000; sync_in = 1'b1;
    tick();
    wr_en = 1'b0; sync_in = 1'b0;
    ticks(2);
    sync_in = 1'b1; tick(); sync_in = 1'b0;
    ticks(2);

    // clear on reload, via sync and via immediate write
    cur_req = "R6";
    wr(1'b1, 32'h0000_001D);
    wr(1'b0, 32'h0050_0000);
    ticks(2);
    sync_in = 1'b1; tick(); sync_in = 1'b0;
    tick();
    check("R6", phase_out, 32'h6000_0000);
    ticks(3);
    wr(1'b1, 32'h0000_000C);
    ticks(2);
    wr(1'b0, 32'h0070_0000);
    tick();
    check("R6", phase_out, 32'h2000_0000);
    ticks(3);

    // continuous clear, with enable both high and low
    cur_req = "R5";
    wr(1'b1, 32'h0000_002A);
    ticks(2);
    check("R5", phase_out, 32'hA000_0000);
    enable = 1'b0; ticks(2);
    enable = 1'b1; ticks(2);
    check("R5", phase_out, 32'hA000_0000);
    wr(1'b1, 32'h0000_0028);
    ticks(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule